// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit CPU with a 16-bit address bus and the memory chips of a plug-in cartridge. Cartridge ROM is read-only, so the CPU changes banks by storing bytes into the ROM address range. The controller catches those stores in four small control registers. A low bank field selects one of 32 ROM banks. A two-bit shared field extends either the ROM bank or the RAM bank. A key register switches the external RAM on or off, and a single steering bit selects how the shared field is used.

From these registers and the current CPU address, the controller builds the wide ROM address for the fixed window at 0x0000–0x3FFF and for the switchable window at 0x4000–0x7FFF. It also builds the external RAM address for the window at 0xA000–0xBFFF, a RAM chip select and a RAM write strobe. It returns the read byte the CPU should see, and an idle bus value of 0xFF is substituted wherever RAM is shut off. Address translation and read steering are purely combinational; only the control registers are clocked.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After a synchronous reset the low bank field holds 1, the shared field, the steering bit and the RAM enable are 0, so address 0x4000 maps to ROM address 0x04000 and the RAM select stays low.
- R2: A clocked store with `cpu_wr` high and `cpu_addr[15]` low updates exactly one register, chosen by `cpu_addr[14:13]`: 0 = RAM key, 1 = low bank (bits 4:0 of the data), 2 = shared field (bits 1:0), 3 = steering bit. Stores at 0x8000 and above leave all registers unchanged.
- R3: If the five low bank bits are zero they are used as 1. Only those five bits are examined, so banks 0x20, 0x40 and 0x60 become 0x21, 0x41 and 0x61.
- R4: For addresses 0x4000–0x7FFF, `rom_addr` = {shared field, corrected low bank, `cpu_addr[13:0]`}, which is 21 bits.
- R5: For addresses 0x0000–0x3FFF, `rom_addr` uses bank 0 when the steering bit is 0 and bank {shared field, 00000} when it is 1.
- R6: RAM is enabled when the low nibble of the byte stored to the key register is 0xA, so 0x1A enables it. Any other nibble disables it, for example 0xA0.
- R7: `ram_addr` = {RAM bank, `cpu_addr[12:0]`}. The RAM bank is the shared field when the steering bit is 1 and 0 when it is 0. Only bit 0 of a steering store counts.
- R8: `ram_cs` is high only for addresses 0xA000–0xBFFF while RAM is enabled. `ram_we` equals `ram_cs` AND `cpu_wr`, so stores to disabled RAM produce no strobe.
- R9: `cpu_rdata` passes `rom_rdata` below 0x8000. It passes `ram_rdata` in the RAM window while RAM is enabled. It returns 0xFF in the RAM window while RAM is disabled, and at every other address.
- R10: A register store takes effect at the clock edge that ends its bus cycle. Translation during the store cycle still uses the previous register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU store data |
| cpu_wr | input | 1 | CPU store qualifier for the current bus cycle |
| rom_rdata | input | 8 | Byte returned by the ROM array |
| ram_rdata | input | 8 | Byte returned by the RAM array |
| rom_addr | output | 21 | Full ROM array address |
| ram_addr | output | 15 | Full RAM array address |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write strobe |
| cpu_rdata | output | 8 | Byte returned to the CPU |

## Verification
A store to a control register and the translation of that same address happen in the same bus cycle. For example, a store to 0x4000 changes the shared field while 0x4000 is also being mapped into the switchable window. The bench provokes this overlap with the steering bit set. It samples `rom_addr` just before the latching edge and expects the old bank, then samples again after the edge, with the address held, and expects the new bank. The same overlap arises when a RAM-window store meets the RAM key, and the bench judges it through `ram_we`.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    parameter int ADDR_W    = 16;
    parameter int DATA_W    = 8;
    parameter int LO_W      = 5;
    parameter int HI_W      = 2;
    parameter int ROM_OFS_W = 14;
    parameter int RAM_OFS_W = 13;

    localparam int BANK_W     = LO_W + HI_W;
    localparam int ROM_ADDR_W = BANK_W + ROM_OFS_W;
    localparam int RAM_ADDR_W = HI_W + RAM_OFS_W;
    localparam int NIB_W      = DATA_W / 2;

    localparam logic [NIB_W-1:0]  EN_KEY    = NIB_W'(4'hA);
    localparam logic [2:0]        RAM_WIN   = 3'b101;
    localparam logic [DATA_W-1:0] IDLE_BYTE = '1;

    typedef enum logic [1:0] {
        SEL_RAM_KEY = 2'd0,
        SEL_LO_BANK = 2'd1,
        SEL_SHARED  = 2'd2,
        SEL_STEER   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic            ram_en;
        logic            steer;
        logic [HI_W-1:0] shared;
        logic [LO_W-1:0] lo;
    } bank_regs_t;

    localparam bank_regs_t REGS_RESET = '{ram_en: 1'b0, steer: 1'b0,
                                          shared: '0, lo: LO_W'(1)};

    function automatic logic [LO_W-1:0] lift_zero(input logic [LO_W-1:0] v);
        return (v == '0) ? LO_W'(1) : v;
    endfunction

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[ADDR_W-2 -: 2]);
    endfunction

    function automatic logic in_ram_window(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: 3] == RAM_WIN;
    endfunction

endpackage

// File: rtl/cbc_ctrl_regs.sv
module cbc_ctrl_regs
    import cbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output bank_regs_t        regs
);

    logic     store_hit;
    reg_sel_e sel;

    assign store_hit = cpu_wr && !cpu_addr[ADDR_W-1];
    assign sel       = decode_sel(cpu_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= REGS_RESET;
        end else if (store_hit) begin
            unique case (sel)
                SEL_RAM_KEY: regs.ram_en <= (cpu_wdata[NIB_W-1:0] == EN_KEY);
                SEL_LO_BANK: regs.lo     <= cpu_wdata[LO_W-1:0];
                SEL_SHARED:  regs.shared <= cpu_wdata[HI_W-1:0];
                SEL_STEER:   regs.steer  <= cpu_wdata[0];
                default:     regs        <= regs;
            endcase
        end
    end

    // R2: without a store into the ROM range, no register moves
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && !cpu_addr[ADDR_W-1]) |=> $stable(regs));

    // R10: the steering bit follows data bit 0 of the previous cycle's store
    assert_steer_bit0_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[ADDR_W-1 -: 3] == 3'b011) |=> regs.steer == $past(cpu_wdata[0]));

    // R6: a key store with the wrong nibble leaves RAM disabled
    assert_bad_key_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[ADDR_W-1 -: 3] == 3'b000 && cpu_wdata[NIB_W-1:0] != EN_KEY)
        |=> !regs.ram_en);

endmodule

// File: rtl/cbc_bank_map.sv
module cbc_bank_map
    import cbc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-2:0]     addr_lo,
    input  logic                  steer,
    input  logic [HI_W-1:0]       shared,
    input  logic [LO_W-1:0]       lo,
    output logic [ROM_ADDR_W-1:0] rom_addr,
    output logic [RAM_ADDR_W-1:0] ram_addr
);

    logic [BANK_W-1:0] bank_switch;
    logic [BANK_W-1:0] bank_fixed;
    logic [HI_W-1:0]   ram_bank;
    logic              upper_window;

    assign upper_window = addr_lo[ROM_OFS_W];
    assign bank_switch  = {shared, lift_zero(lo)};
    assign bank_fixed   = steer ? {shared, {LO_W{1'b0}}} : '0;
    assign ram_bank     = steer ? shared : '0;

    always_comb begin
        rom_addr = {upper_window ? bank_switch : bank_fixed, addr_lo[ROM_OFS_W-1:0]};
        ram_addr = {ram_bank, addr_lo[RAM_OFS_W-1:0]};
    end

    // R3: the switchable window never lands on a bank whose low bits are zero
    assert_low_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        upper_window |-> rom_addr[ROM_OFS_W +: LO_W] != '0);

    // R7: with the steering bit clear, RAM always uses bank 0
    assert_ram_bank0_R7: assert property (@(posedge clk) disable iff (rst)
        !steer |-> ram_addr[RAM_ADDR_W-1 -: HI_W] == '0);

    // R5: in the fixed window, the low bank bits are always zero
    assert_fixed_low_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !upper_window |-> rom_addr[ROM_OFS_W +: LO_W] == '0);

endmodule

// File: rtl/cbc_ram_gate.sv
module cbc_ram_gate
    import cbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              ram_en,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [DATA_W-1:0] cpu_rdata
);

    logic in_rom;
    logic in_ram;

    assign in_rom = !cpu_addr[ADDR_W-1];
    assign in_ram = in_ram_window(cpu_addr);

    always_comb begin
        ram_cs = in_ram && ram_en;
        ram_we = ram_cs && cpu_wr;
        if (in_rom)      cpu_rdata = rom_rdata;
        else if (ram_cs) cpu_rdata = ram_rdata;
        else             cpu_rdata = IDLE_BYTE;
    end

    // R8: no write strobe without a chip select
    assert_we_needs_cs_R8: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_cs && cpu_wr));

    // R8: chip select only while enabled and in the RAM window
    assert_cs_gated_R8: assert property (@(posedge clk) disable iff (rst)
        ram_cs |-> (ram_en && cpu_addr[ADDR_W-1 -: 3] == 3'b101));

    // R9: disabled RAM reads back as the idle byte
    assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[ADDR_W-1 -: 3] == 3'b101 && !ram_en) |-> cpu_rdata == IDLE_BYTE);

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [DATA_W-1:0]     cpu_wdata,
    input  logic                  cpu_wr,
    input  logic [DATA_W-1:0]     rom_rdata,
    input  logic [DATA_W-1:0]     ram_rdata,
    output logic [ROM_ADDR_W-1:0] rom_addr,
    output logic [RAM_ADDR_W-1:0] ram_addr,
    output logic                  ram_cs,
    output logic                  ram_we,
    output logic [DATA_W-1:0]     cpu_rdata
);

    bank_regs_t regs;

    cbc_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .regs      (regs)
    );

    cbc_bank_map u_map (
        .clk      (clk),
        .rst      (rst),
        .addr_lo  (cpu_addr[ADDR_W-2:0]),
        .steer    (regs.steer),
        .shared   (regs.shared),
        .lo       (regs.lo),
        .rom_addr (rom_addr),
        .ram_addr (ram_addr)
    );

    cbc_ram_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .ram_en    (regs.ram_en),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we),
        .cpu_rdata (cpu_rdata)
    );

    // R1: a reset cycle always leaves RAM deselected
    assert_reset_cs_low_R1: assert property (@(posedge clk)
        $rose(rst) |=> !ram_cs);

endmodule

// File: tb/test_cart_bank_ctrl.sv
module test_cart_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  rom_rdata = 8'h5A;
    logic [7:0]  ram_rdata = 8'h3C;
    logic [20:0] rom_addr;
    logic [14:0] ram_addr;
    logic        ram_cs;
    logic        ram_we;
    logic [7:0]  cpu_rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cart_bank_ctrl i_cart_bank_ctrl (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
        .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_cs(ram_cs),
        .ram_we(ram_we), .cpu_rdata(cpu_rdata)
    );

    // {store, addr, data, expected, requirement}
    // expected: rom_addr below 0x8000, else {5'b0, ram_cs, ram_addr}
    localparam int NV = 26;
    localparam logic [49:0] VEC [NV] = '{
        {1'b0, 16'h4000, 8'h00, 21'h004000, 4'd1},  // R1 reset bank 1
        {1'b0, 16'h0123, 8'h00, 21'h000123, 4'd5},  // R5 fixed window, steer 0
        {1'b1, 16'h2000, 8'h00, 21'h0,      4'd3},
        {1'b0, 16'h5ABC, 8'h00, 21'h005ABC, 4'd3},  // R3 zero becomes 1
        {1'b1, 16'h3FFF, 8'h13, 21'h0,      4'd2},
        {1'b0, 16'h4001, 8'h00, 21'h04C001, 4'd4},  // R4 bank 0x13
        {1'b1, 16'h2000, 8'hE7, 21'h0,      4'd2},
        {1'b0, 16'h7FFF, 8'h00, 21'h01FFFF, 4'd2},  // R2 only bits 4:0 kept
        {1'b1, 16'h4000, 8'h02, 21'h0,      4'd4},
        {1'b0, 16'h4000, 8'h00, 21'h11C000, 4'd4},  // R4 bank 0x47
        {1'b1, 16'h2000, 8'h00, 21'h0,      4'd3},
        {1'b0, 16'h4000, 8'h00, 21'h104000, 4'd3},  // R3 0x40 -> 0x41
        {1'b0, 16'h1000, 8'h00, 21'h001000, 4'd5},  // R5 steer 0 -> bank 0
        {1'b1, 16'h6000, 8'h01, 21'h0,      4'd5},
        {1'b0, 16'h1000, 8'h00, 21'h101000, 4'd5},  // R5 steer 1 -> bank 0x40
        {1'b0, 16'hA123, 8'h00, 21'h004123, 4'd7},  // R7 RAM bank 2, cs low
        {1'b1, 16'h0000, 8'h1A, 21'h0,      4'd6},
        {1'b0, 16'hBFFF, 8'h00, 21'h00DFFF, 4'd6},  // R6 0x1A enables
        {1'b1, 16'h6000, 8'hFE, 21'h0,      4'd7},
        {1'b0, 16'hA000, 8'h00, 21'h008000, 4'd7},  // R7 steer bit0=0 -> bank 0
        {1'b1, 16'h1FFF, 8'hA0, 21'h0,      4'd6},
        {1'b0, 16'hA000, 8'h00, 21'h000000, 4'd6},  // R6 0xA0 disables
        {1'b1, 16'h9000, 8'h00, 21'h0,      4'd2},
        {1'b0, 16'h4000, 8'h00, 21'h104000, 4'd2},  // R2 store at 0x9000 ignored
        {1'b1, 16'h5000, 8'hFF, 21'h0,      4'd3},
        {1'b0, 16'h4000, 8'h00, 21'h184000, 4'd3}   // R3 0x60 -> 0x61
    };

    task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic store(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic look(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a;
        #1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][49]) begin
                store(VEC[i][48:33], VEC[i][32:25]);
            end else begin
                look(VEC[i][48:33]);
                if (!VEC[i][48])
                    check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rom_addr, VEC[i][24:4]);
                else
                    check($sformatf("R%0d vec%0d", VEC[i][3:0], i),
                          {5'b0, ram_cs, ram_addr}, VEC[i][24:4]);
            end
        end

        // R10: store to the shared field while 0x4000 is mapped, steer = 1
        store(16'h6000, 8'h01);             // shared=3, lo=0 (eff 1)
        @(negedge clk);
        cpu_addr = 16'h4000; cpu_wdata = 8'h01; cpu_wr = 1'b1;
        #1 check("R10 before edge", rom_addr, 21'h184000);
        @(negedge clk);
        cpu_wr = 1'b0;
        #1 check("R10 after edge", rom_addr, 21'h084000);

        // R9 read steering
        look(16'h2000);
        check("R9 rom pass", {13'b0, cpu_rdata}, 21'h5A);
        look(16'hA010);
        check("R9 ram off", {13'b0, cpu_rdata}, 21'hFF);
        store(16'h0000, 8'h0A);
        look(16'hA010);
        check("R9 ram on", {13'b0, cpu_rdata}, 21'h3C);
        look(16'hC000);
        check("R9 other area", {13'b0, cpu_rdata}, 21'hFF);

        // R8 write strobe, enabled then disabled
        @(negedge clk);
        cpu_addr = 16'hA010; cpu_wr = 1'b1;
        #1 check("R8 we enabled", {20'b0, ram_we}, 21'h1);
        @(negedge clk);
        cpu_wr = 1'b0;
        #1 check("R8 we idle", {20'b0, ram_we}, 21'h0);
        store(16'h0000, 8'h00);
        @(negedge clk);
        cpu_addr = 16'hA010; cpu_wr = 1'b1;
        #1 check("R8 we disabled", {19'b0, ram_cs, ram_we}, 21'h0);
        @(negedge clk);
        cpu_wr = 1'b0;

        // R1 mid-run reset after enabling RAM and changing banks
        store(16'h0000, 8'h0A);
        store(16'h2000, 8'h09);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        look(16'h4000);
        check("R1 bank after reset", rom_addr, 21'h004000);
        look(16'hA000);
        check("R1 ram off after reset", {5'b0, ram_cs, ram_addr}, 21'h000000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule